// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This controller gathers level requests from a set of on-chip sources and drives one interrupt line toward a host processor. Software sets it up through a four-word register port. It chooses which sources take part with a mask word, picks one source to promote above all the others, and turns delivery on with a global enable bit. It also selects the processor-side request level, which the block only passes through to a port.

To take an interrupt, the host writes a one to bit 0 of the vector word. The controller then picks the best eligible source and records it as in service. The host reads the vector word back and finds the source number in bits [15:11]. To end service, the host writes a one to that source's bit in the in-service word. While a source is in service, it and every source ranked at or below it are held off. A source ranked higher can still interrupt, so service can nest.

Code 0 is reserved as the error vector. The host receives it when an acknowledge finds nothing to deliver. This happens, for example, when a request was masked between raising the line and the acknowledge. No in-service state is recorded for the error vector.

Top module: `vic_top`

## Requirements
- R1: After reset, all four register words read 0, `irq_o` is low and `irq_level_o` is 0.
- R2: A source whose bit in the mask word (address 1, bit i for source i) is 0 cannot raise `irq_o`. Setting that bit lets its request through.
- R3: The control word (address 0) has an enable bit at bit 8. While that bit is 0, `irq_o` stays low and an acknowledge returns the error vector.
- R4: Writing the vector word (address 3) with bit 0 set latches the winning source. Reading address 3 returns the number in bits [15:11] and zeros elsewhere. A write with bit 0 clear leaves the latched vector unchanged.
- R5: Among eligible sources, the higher source number wins. Source 0 is reserved, and its request is ignored.
- R6: Control bits [4:0] name one source that outranks every other source.
- R7: A delivered source sets its bit in the in-service word (address 2). While that bit is set, the source and every source of equal or lower rank neither raise `irq_o` nor win an acknowledge.
- R8: Writing the in-service word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: An acknowledge that finds no eligible source, including one whose request was masked after `irq_o` rose, latches vector 0 and changes no in-service bit.
- R10: Control bits [15:13] read back and drive `irq_level_o`.
- R11: A source that outranks every in-service source raises `irq_o` and wins the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Level request per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt request to the host |
| irq_level_o | output | 3 | Programmed host request level |

## Verification
A corrupted in-service word shows up at the ports in one of two ways. Either `irq_o` stays low while a higher-ranked request is pending, or it rises for a source that should be held off. In both cases the effect is visible in the same cycle the request changes, and the in-service word also reads back wrong right after the acknowledge. A wrong rank map or a wrong arbiter pick shows in the vector read that directly follows the acknowledge. A sweep over every promoted-source setting and many source pairs compares each pick with a rank computed in the bench.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VEC_W     = 5;
    localparam int RANK_W    = VEC_W + 1;
    localparam int EN_BIT    = 8;
    localparam int LVL_LSB   = 13;
    localparam int LVL_W     = 3;
    localparam int VEC_LSB   = 11;
    localparam int ACK_BIT   = 0;
    localparam int DATA_W    = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_INSVC = 2'd2,
        SEL_VECT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             en;
        logic [VEC_W-1:0] top;
    } ctrl_t;
endpackage

// File: rtl/vic_rank_map.sv
module vic_rank_map
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [VEC_W-1:0]                 top_i,
    output logic [NUM_SRC-1:0][RANK_W-1:0]   rank_o
);
    localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(1 << VEC_W);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
        assign rank_o[i] = (top_i == VEC_W'(i)) ? TOP_RANK : RANK_W'(i);
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]               cand_i,
    input  logic [NUM_SRC-1:0][RANK_W-1:0]   rank_i,
    output logic                             valid_o,
    output logic [VEC_W-1:0]                 idx_o,
    output logic [RANK_W-1:0]                best_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand_i[i] && (rank_i[i] > best_o)) begin
                valid_o = 1'b1;
                idx_o   = VEC_W'(i);
                best_o  = rank_i[i];
            end
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   req_i,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_o,
    output logic [LVL_W-1:0]     irq_level_o
);
    typedef struct packed {
        ctrl_t              ctrl;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] isr;
        logic [VEC_W-1:0]   vec;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0][RANK_W-1:0] rank;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             elig;
    logic                           isr_valid_unused;
    logic [VEC_W-1:0]               isr_idx_unused;
    logic [RANK_W-1:0]              isr_best;
    logic                           win_valid;
    logic [VEC_W-1:0]               win_idx;
    logic [RANK_W-1:0]              win_best_unused;
    logic                           ack_fire;

    vic_rank_map #(.NUM_SRC(NUM_SRC)) u_rank (
        .top_i  (st_q.ctrl.top),
        .rank_o (rank)
    );

    // highest rank currently in service
    vic_arbiter #(.NUM_SRC(NUM_SRC)) u_isr_arb (
        .cand_i  (st_q.isr),
        .rank_i  (rank),
        .valid_o (isr_valid_unused),
        .idx_o   (isr_idx_unused),
        .best_o  (isr_best)
    );

    // source 0 is the reserved error code and never competes
    assign pend = req_i & st_q.mask & ~NUM_SRC'(1);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = pend[i] && (rank[i] > isr_best);
    end

    vic_arbiter #(.NUM_SRC(NUM_SRC)) u_win_arb (
        .cand_i  (elig),
        .rank_i  (rank),
        .valid_o (win_valid),
        .idx_o   (win_idx),
        .best_o  (win_best_unused)
    );

    assign ack_fire = reg_we && (reg_addr == SEL_VECT) && reg_wdata[ACK_BIT];

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            unique case (reg_sel_e'(reg_addr))
                SEL_CTRL: begin
                    st_d.ctrl.top   = reg_wdata[VEC_W-1:0];
                    st_d.ctrl.en    = reg_wdata[EN_BIT];
                    st_d.ctrl.level = reg_wdata[LVL_LSB +: LVL_W];
                end
                SEL_MASK:  st_d.mask = reg_wdata[NUM_SRC-1:0];
                SEL_INSVC: st_d.isr  = st_q.isr & ~reg_wdata[NUM_SRC-1:0];
                SEL_VECT: begin
                    if (reg_wdata[ACK_BIT]) begin
                        if (st_q.ctrl.en && win_valid) begin
                            st_d.vec = win_idx;
                            st_d.isr = st_q.isr | (NUM_SRC'(1) << win_idx);
                        end else begin
                            st_d.vec = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_CTRL: begin
                reg_rdata[VEC_W-1:0]         = st_q.ctrl.top;
                reg_rdata[EN_BIT]            = st_q.ctrl.en;
                reg_rdata[LVL_LSB +: LVL_W]  = st_q.ctrl.level;
            end
            SEL_MASK:  reg_rdata[NUM_SRC-1:0]       = st_q.mask;
            SEL_INSVC: reg_rdata[NUM_SRC-1:0]       = st_q.isr;
            SEL_VECT:  reg_rdata[VEC_LSB +: VEC_W]  = st_q.vec;
            default: ;
        endcase
    end

    assign irq_o       = st_q.ctrl.en && (|elig);
    assign irq_level_o = st_q.ctrl.level;

    // R7 / R4: a delivered acknowledge records the winner and marks it in service
    assert_ack_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && st_q.ctrl.en && win_valid)
            |=> (st_q.isr[$past(win_idx)] && (st_q.vec == $past(win_idx))));

    // R9: an empty acknowledge yields code 0 and leaves in-service state alone
    assert_err_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !(st_q.ctrl.en && win_valid))
            |=> ((st_q.vec == '0) && $stable(st_q.isr)));

    // R8: in-service write clears only the ones written
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == SEL_INSVC))
            |=> (st_q.isr == ($past(st_q.isr) & ~$past(reg_wdata[NUM_SRC-1:0]))));

    // R2: the line never rises without an unmasked request
    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(req_i & st_q.mask)));

    // R5: the reserved code never becomes in service
    assert_no_src0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.isr[0]);
endmodule

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o;
    logic [2:0]    irq_level_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vic_top #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_req(input logic [N-1:0] v);
        @(negedge clk);
        req_i = v;
        #1;
    endtask

    function automatic logic [31:0] ctrl_word(input int top, input bit en, input int lvl);
        return (32'(lvl) << 13) | (32'(en) << 8) | 32'(top);
    endfunction

    function automatic int rk(input int i, input int top);
        return (i == top) ? 32 : i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reg reset", v, 32'h0);
        end
        chk("R1 irq reset", 32'(irq_o), 0);
        chk("R1 level reset", 32'(irq_level_o), 0);

        // R10 level field
        wr(0, ctrl_word(0, 0, 5));
        chk("R10 level port", 32'(irq_level_o), 5);
        rd(0, v); chk("R10 ctrl readback", v, ctrl_word(0, 0, 5));
        wr(0, ctrl_word(0, 0, 0));

        // per-source sweep: R2 R3 R4 R7 R8
        for (int s = 1; s < N; s++) begin
            wr(1, 32'h0);
            wr(0, ctrl_word(0, 1, 0));
            set_req(N'(1) << s);
            chk("R2 masked no irq", 32'(irq_o), 0);
            wr(0, ctrl_word(0, 0, 0));
            wr(1, 32'(1) << s);
            chk("R3 disabled no irq", 32'(irq_o), 0);
            wr(0, ctrl_word(0, 1, 0));
            chk("R2 unmasked irq", 32'(irq_o), 1);
            wr(3, 32'h1);
            rd(3, v); chk("R4 vector read", v, 32'(s) << 11);
            rd(2, v); chk("R7 insvc set", v, 32'(1) << s);
            chk("R7 self blocked", 32'(irq_o), 0);
            wr(2, ~(32'(1) << s));
            rd(2, v); chk("R8 zero bits keep", v, 32'(1) << s);
            wr(2, 32'(1) << s);
            rd(2, v); chk("R8 one clears", v, 32'h0);
            chk("R8 irq returns", 32'(irq_o), 1);
            set_req('0);
        end

        // R4 ack bit clear has no effect
        wr(3, 32'hFFFF_FFFE);
        rd(3, v); chk("R4 no ack keeps vector", v, 32'(N-1) << 11);

        // R5 source 0 ignored
        wr(1, 32'hFFFF_FFFF);
        set_req(N'(1));
        chk("R5 src0 no irq", 32'(irq_o), 0);
        wr(3, 32'h1);
        rd(3, v); chk("R5 src0 gives error code", v, 32'h0);
        rd(2, v); chk("R9 no insvc on error", v, 32'h0);

        // R5 R6 pair sweep over every promoted setting
        for (int t = 0; t < N; t++) begin
            wr(0, ctrl_word(t, 1, 0));
            for (int a = 1; a < N; a += 2) begin
                int b;
                int ex;
                b = ((a * 11) % (N - 1)) + 1;
                ex = (rk(a, t) >= rk(b, t)) ? a : b;
                set_req((N'(1) << a) | (N'(1) << b));
                wr(3, 32'h1);
                rd(3, v); chk("R6 R5 pair winner", v, 32'(ex) << 11);
                wr(2, 32'hFFFF_FFFF);
            end
        end

        // R6 promoted source blocks all when in service
        wr(0, ctrl_word(2, 1, 0));
        set_req(N'(1) << 2);
        wr(3, 32'h1);
        set_req(N'(1) << 31);
        chk("R6 promoted blocks top number", 32'(irq_o), 0);
        wr(2, 32'hFFFF_FFFF);

        // R7 R11 nesting
        wr(0, ctrl_word(0, 1, 0));
        set_req(N'(1) << 5);
        wr(3, 32'h1);
        set_req((N'(1) << 5) | (N'(1) << 9));
        chk("R11 higher interrupts", 32'(irq_o), 1);
        set_req((N'(1) << 5) | (N'(1) << 3));
        chk("R7 lower blocked", 32'(irq_o), 0);
        wr(3, 32'h1);
        rd(3, v); chk("R7 lower not acked", v, 32'h0);
        set_req((N'(1) << 9) | (N'(1) << 3));
        wr(3, 32'h1);
        rd(3, v); chk("R11 nested vector", v, 32'(9) << 11);
        rd(2, v); chk("R11 nested insvc", v, (32'(1) << 5) | (32'(1) << 9));
        wr(2, 32'(1) << 9);
        rd(2, v); chk("R8 partial clear", v, 32'(1) << 5);
        wr(2, 32'hFFFF_FFFF);

        // R9 masked after raise
        set_req(N'(1) << 7);
        chk("R9 irq raised", 32'(irq_o), 1);
        wr(1, 32'h0);
        wr(3, 32'h1);
        rd(3, v); chk("R9 race error vector", v, 32'h0);
        rd(2, v); chk("R9 race no insvc", v, 32'h0);

        // R3 ack while disabled
        wr(1, 32'hFFFF_FFFF);
        wr(0, ctrl_word(0, 0, 0));
        wr(3, 32'h1);
        rd(3, v); chk("R3 disabled ack error", v, 32'h0);
        rd(2, v); chk("R3 disabled no insvc", v, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule